// File: doc/BRIEF.md
# Command Ring DMA Register Block

This block holds the software-visible registers of a DMA engine that fetches commands from a ring buffer in memory. It has three byte-wide registers: a control register, a status register and a read-only size register. A simple register port reaches all three. The control register drives a run request to the engine and enables an interrupt. The engine reports an idle indication and memory-error events back to the block.

Stopping is a handshake. When software clears the run request, the engine is told to stop at once. The readable run bit stays 1 until the engine reports idle, so software polls it to confirm a stop. A memory error latches into a write-1-to-clear status bit. When this bit is set and the interrupt is enabled, a level interrupt is raised. The only way back to a usable state is a full synchronous reset.

Top module: `ring_dma_regs`

## Requirements
- R1: A synchronous active-high reset returns control and status to 0x00, clears the run output and clears the interrupt, whatever state came before.
- R2: A write to offset 0x4C loads control bit 1 (run request, 1 = run) and bit 0 (error interrupt enable). The run output follows the run request from the cycle after the write.
- R3: The run bit read from 0x4C is 1 while the run request is 1 or the idle input is low. It reads 0 only when the request is 0 and idle is high.
- R4: When the memory-error input is high on a clock edge, status bit 0 at offset 0x4D becomes 1. It stays 1 after the input drops.
- R5: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged. If a memory error and a clearing write happen on the same cycle, the bit stays 1.
- R6: Offset 0x4E always reads 0x42, and writes to it have no effect.
- R7: Reserved bits read as 0: control bits 7:2 and status bits 7:1. Writes to them are ignored.
- R8: A read of any other offset returns 0x00. Writes to any other offset change no register.
- R9: The interrupt output is high exactly while status bit 0 and the enable bit are both 1. It falls in the cycle after a write that clears either one.
- R10: Read data appears in the cycle after the read strobe. It is 0x00 in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regAddr | input | 8 | Register byte offset |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdEn | input | 1 | Read strobe |
| regRdData | output | 8 | Read data, one cycle after the read strobe |
| dmaRun | output | 1 | Run request to the DMA engine |
| dmaIdle | input | 1 | Engine reports it has stopped |
| memErr | input | 1 | Engine reports corrupt fetched data |
| irq | output | 1 | Level memory-error interrupt |

## Verification
The run/stop handshake is exercised with the idle input both low and high after a stop request. This separates the readable run bit from the raw request. The error bit is hit with clearing writes of 1, of 0 and of reserved bits, and with a clear that lands on the same cycle as a new error. This separates write-1-to-clear behaviour from a plain write and shows that the hardware set wins. The interrupt is removed once by clearing the status bit and once by clearing the enable bit. Reads of the size register, of unmapped offsets and of other registers after stray writes show that decoding is limited to the three offsets.

// File: rtl/ring_dma_regs_pkg.sv
package ring_dma_regs_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h4C;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h4D;
  localparam logic [ADDR_W-1:0] OFS_SIZE = 8'h4E;
  localparam logic [DATA_W-1:0] SIZE_VAL = 8'h42;
  localparam int BIT_RUN   = 1;
  localparam int BIT_IRQEN = 0;
  localparam int BIT_ERR   = 0;

  typedef struct packed {
    logic wrCtrl;
    logic wrStat;
    logic rdCtrl;
    logic rdStat;
    logic rdSize;
    logic rdAny;
  } regStrobe_t;
endpackage

// File: rtl/ring_dma_regs_ctrl.sv
module ring_dma_regs_ctrl
  import ring_dma_regs_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output regStrobe_t        strb
);
  logic hitCtrl, hitStat, hitSize;

  always_comb begin
    hitCtrl = (regAddr == OFS_CTRL);
    hitStat = (regAddr == OFS_STAT);
    hitSize = (regAddr == OFS_SIZE);
    strb.wrCtrl = regWrEn && hitCtrl;
    strb.wrStat = regWrEn && hitStat;
    strb.rdCtrl = regRdEn && hitCtrl;
    strb.rdStat = regRdEn && hitStat;
    strb.rdSize = regRdEn && hitSize;
    strb.rdAny  = regRdEn;
  end
endmodule

// File: rtl/ring_dma_regs_dp.sv
module ring_dma_regs_dp
  import ring_dma_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              dmaIdle,
  input  logic              memErr,
  output logic [DATA_W-1:0] rdData,
  output logic              dmaRun,
  output logic              irq
);
  logic runReq, irqEn, errStat;
  logic [DATA_W-1:0] ctrlView, statView, rdNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      runReq <= 1'b0;
      irqEn  <= 1'b0;
    end else if (strb.wrCtrl) begin
      runReq <= wrData[BIT_RUN];
      irqEn  <= wrData[BIT_IRQEN];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      errStat <= 1'b0;
    else if (memErr)
      errStat <= 1'b1;
    else if (strb.wrStat && wrData[BIT_ERR])
      errStat <= 1'b0;
  end

  always_comb begin
    ctrlView = '0;
    ctrlView[BIT_RUN]   = runReq | ~dmaIdle;
    ctrlView[BIT_IRQEN] = irqEn;
    statView = '0;
    statView[BIT_ERR] = errStat;
    rdNext = '0;
    if (strb.rdCtrl)      rdNext = ctrlView;
    else if (strb.rdStat) rdNext = statView;
    else if (strb.rdSize) rdNext = SIZE_VAL;
  end

  always_ff @(posedge clk) begin
    if (rst || !strb.rdAny) rdData <= '0;
    else                    rdData <= rdNext;
  end

  assign dmaRun = runReq;
  assign irq    = errStat & irqEn;

  // R4
  err_set_chk: assert property (@(posedge clk) disable iff (rst) memErr |=> errStat);
  // R5
  stat_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.wrStat && wrData[BIT_ERR] && !memErr) |=> !errStat);
  // R3
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.rdCtrl && !dmaIdle) |=> rdData[BIT_RUN]);
  // R6
  size_rd_chk: assert property (@(posedge clk) disable iff (rst)
    strb.rdSize |=> (rdData == SIZE_VAL));
  // R9
  irq_off_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.wrCtrl && !wrData[BIT_IRQEN]) |=> !irq);
endmodule

// File: rtl/ring_dma_regs.sv
module ring_dma_regs
  import ring_dma_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regRdEn,
  output logic [DATA_W-1:0] regRdData,
  output logic              dmaRun,
  input  logic              dmaIdle,
  input  logic              memErr,
  output logic              irq
);
  regStrobe_t strb;

  ring_dma_regs_ctrl u_ctrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn), .strb(strb)
  );

  ring_dma_regs_dp u_dp (
    .clk(clk), .rst(rst), .strb(strb), .wrData(regWrData),
    .dmaIdle(dmaIdle), .memErr(memErr), .rdData(regRdData),
    .dmaRun(dmaRun), .irq(irq)
  );
endmodule

// File: tb/tb_ring_dma_regs.sv
module tb_ring_dma_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic regRdEn = 1'b0;
  logic [7:0] regRdData;
  logic dmaRun;
  logic dmaIdle = 1'b1;
  logic memErr = 1'b0;
  logic irq;

  int total = 0;
  int bad = 0;
  logic [7:0] expQ[$];
  string tagQ[$];
  logic rdPending = 1'b0;

  always #5 clk = ~clk;

  ring_dma_regs dut (.*);

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected value one cycle after each read strobe
  always @(negedge clk) begin
    if (rdPending) begin
      if (expQ.size() == 0) check("R10 unexpected read", regRdData, 8'h00);
      else check(tagQ.pop_front(), regRdData, expQ.pop_front());
    end
    rdPending = regRdEn;
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(posedge clk); #1;
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] e, string tag);
    @(posedge clk); #1;
    regAddr = a; regRdEn = 1'b1;
    expQ.push_back(e); tagQ.push_back(tag);
    @(posedge clk); #1;
    regRdEn = 1'b0;
  endtask

  task automatic errPulse();
    @(posedge clk); #1; memErr = 1'b1;
    @(posedge clk); #1; memErr = 1'b0;
  endtask

  task automatic portCheck(string tag, logic act, logic exp);
    @(negedge clk);
    check(tag, {7'b0, act}, {7'b0, exp});
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    rd(8'h4C, 8'h00, "R1 ctrl reset");
    rd(8'h4D, 8'h00, "R1 stat reset");
    portCheck("R1 run reset", dmaRun, 1'b0);
    portCheck("R1 irq reset", irq, 1'b0);
    portCheck("R10 idle read data", {regRdData != 0}, 1'b0);
    // R2 / R7
    wr(8'h4C, 8'hFF);
    portCheck("R2 run follows", dmaRun, 1'b1);
    rd(8'h4C, 8'h03, "R7 ctrl reserved");
    // R3 stop handshake
    dmaIdle = 1'b0;
    wr(8'h4C, 8'h01);
    portCheck("R2 run drops", dmaRun, 1'b0);
    rd(8'h4C, 8'h03, "R3 busy reads run");
    dmaIdle = 1'b1;
    rd(8'h4C, 8'h01, "R3 idle reads stop");
    // R4 / R9
    errPulse();
    rd(8'h4D, 8'h01, "R4 err latched");
    portCheck("R9 irq set", irq, 1'b1);
    // R5 / R7
    wr(8'h4D, 8'h00);
    rd(8'h4D, 8'h01, "R5 write zero keeps");
    wr(8'h4D, 8'hFE);
    rd(8'h4D, 8'h01, "R7 stat reserved write");
    @(posedge clk); #1;
    regAddr = 8'h4D; regWrData = 8'h01; regWrEn = 1'b1; memErr = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0; memErr = 1'b0;
    rd(8'h4D, 8'h01, "R5 set wins");
    wr(8'h4D, 8'h01);
    portCheck("R9 irq drops on clear", irq, 1'b0);
    rd(8'h4D, 8'h00, "R5 w1c clears");
    // R9 enable path
    errPulse();
    portCheck("R9 irq again", irq, 1'b1);
    wr(8'h4C, 8'h00);
    portCheck("R9 irq drops on disable", irq, 1'b0);
    // R6
    rd(8'h4E, 8'h42, "R6 size value");
    wr(8'h4E, 8'h00);
    rd(8'h4E, 8'h42, "R6 size write ignored");
    // R8
    wr(8'h4F, 8'hFF);
    wr(8'h4B, 8'hFF);
    rd(8'h4F, 8'h00, "R8 unmapped 4F");
    rd(8'h4B, 8'h00, "R8 unmapped 4B");
    rd(8'h4C, 8'h00, "R8 ctrl untouched");
    rd(8'h4D, 8'h01, "R8 stat untouched");
    // R1 reset from busy state
    wr(8'h4C, 8'h03);
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    portCheck("R1 run after reset", dmaRun, 1'b0);
    portCheck("R1 irq after reset", irq, 1'b0);
    rd(8'h4C, 8'h00, "R1 ctrl after reset");
    rd(8'h4D, 8'h00, "R1 stat after reset");
    repeat (3) @(posedge clk);
    if (expQ.size() != 0) check("R10 missing read", 8'h00, 8'h01);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule